// File: doc/BRIEF.md
# DMA Channel Status and Condition Unit

This block keeps the run-state and device-status word of one descriptor-driven DMA channel. It also holds three selector registers, one each for interrupt, branch and wait. Software changes the status word through masked writes, so a single write can set or clear any chosen group of bits and leave the others alone. The channel's data path can also update the low device-status byte with its own mask and value.

Each selector holds a mask byte and a value byte. A selector's condition holds when the device-status byte, ANDed with the mask, equals the value. When the descriptor engine presents a command, it supplies a 2-bit gate code for each of the three conditions. The block turns each condition and its code into a registered interrupt, branch-taken or wait-hold output. The branch decision is also stored in the status word, so software can tell whether the current command branched. Descriptor fetch, data movement and bus mastering belong to neighbouring blocks.

Top module: `chan_status_unit`

## Requirements
- R1: After a synchronous reset, every status bit, every selector, the branch flag and the outputs `irq`, `branch_taken`, `wait_hold` and `rd_data` are zero.
- R2: A write to address 0 carries a 16-bit mask in `wr_data[31:16]` and a 16-bit value in `wr_data[15:0]`. Each status bit in 15:11 or 7:0 whose mask bit is 1 takes its value bit. Unmasked bits keep their state, and software cannot change bits 10:8 at all. Example: with a device byte of 0xFF, mask 0x0003 and value 0 leave 0xFC.
- R3: Status bits 15 to 10 are, in order, run, pause, flush, wake, dead and active. Active (bit 10) reads 1 exactly when run is 1 and dead is 0. Bit 9 reads 0.
- R4: When `hw_dev_we` is high, each device-status bit (7:0) selected by `hw_dev_mask` takes its bit of `hw_dev_val`. If a software write to address 0 arrives in the same cycle, the hardware value wins on the bits the hardware mask selects.
- R5: Writes to address 1 (interrupt), 2 (branch) and 3 (wait) load that selector from `wr_data[15:0]`, with the mask in bits 15:8 and the value in bits 7:0. A read returns the selector as {mask, value}.
- R6: A selector's condition is true when (device-status byte & mask) == value.
- R7: When `cmd_eval` is high, each output is registered one cycle later from its own condition and gate code: 0 gives never, 1 gives the condition, 2 gives its inverse, 3 gives always. In a cycle after `cmd_eval` was low, all three outputs are 0.
- R8: Every command evaluation writes the branch decision into status bit 8. Bit 8 holds its value between evaluations.
- R9: An evaluation uses the status and selector contents as they stood before any write in the same cycle. A write made in the same cycle as an evaluation takes effect from the following cycle.
- R10: `rd_data` is registered. It shows the register at the `rd_addr` of the previous cycle, with contents as they stood before that cycle's writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_addr | input | 2 | Write target: 0 status, 1 interrupt, 2 branch, 3 wait selector |
| wr_data | input | 32 | Write word: mask and value, as given in R2 and R5 |
| rd_addr | input | 2 | Read target, same map as `wr_addr` |
| rd_data | output | 16 | Registered read data |
| hw_dev_we | input | 1 | Hardware device-status update strobe |
| hw_dev_mask | input | 8 | Device-status bits the hardware changes |
| hw_dev_val | input | 8 | New values for those bits |
| cmd_eval | input | 1 | Evaluate the conditions for the current command |
| int_code | input | 2 | Gate code for the interrupt condition |
| br_code | input | 2 | Gate code for the branch condition |
| wait_code | input | 2 | Gate code for the wait condition |
| irq | output | 1 | Registered interrupt request |
| branch_taken | output | 1 | Registered branch decision |
| wait_hold | output | 1 | Registered wait hold |

## Verification
The assertions assume that every input has a defined value in each cycle after reset. They also assume that a software write and a hardware update may touch the same device bit in the same cycle, and they expect the hardware value to be the one that remains. The stimulus drives all inputs away from the clock edge with defined values. It then deliberately creates these collisions, and also writes to a selector in the same cycle that the selector is being evaluated, so the ordering rules are exercised rather than avoided. The upper half of `wr_data` is randomised during selector writes, to show that those bits are ignored.

// File: rtl/chan_status_pkg.sv
package chan_status_pkg;

  typedef enum logic [1:0] {
    GATE_NEVER    = 2'd0,
    GATE_IF_TRUE  = 2'd1,
    GATE_IF_FALSE = 2'd2,
    GATE_ALWAYS   = 2'd3
  } gate_code_e;

  typedef enum logic [1:0] {
    ADR_STATUS   = 2'd0,
    ADR_IRQ_SEL  = 2'd1,
    ADR_BR_SEL   = 2'd2,
    ADR_WAIT_SEL = 2'd3
  } reg_addr_e;

  localparam int NUM_SEL = 3;

  function automatic logic apply_gate(input logic [1:0] code, input logic hit);
    logic r;
    unique case (gate_code_e'(code))
      GATE_NEVER:    r = 1'b0;
      GATE_IF_TRUE:  r = hit;
      GATE_IF_FALSE: r = ~hit;
      default:       r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/chan_status_reg.sv
module chan_status_reg #(
  parameter int DEV_W  = 8,
  parameter int STAT_W = 2 * DEV_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic [STAT_W-1:0] sw_mask,
  input  logic [STAT_W-1:0] sw_val,
  input  logic              hw_we,
  input  logic [DEV_W-1:0]  hw_mask,
  input  logic [DEV_W-1:0]  hw_val,
  input  logic              br_upd,
  input  logic              br_take,
  output logic [STAT_W-1:0] stat_word,
  output logic [DEV_W-1:0]  dev_stat
);

  localparam int RUN_BIT  = STAT_W - 1;
  localparam int DEAD_BIT = STAT_W - 5;
  localparam int ACT_BIT  = STAT_W - 6;
  localparam int BR_BIT   = DEV_W;
  // bits software may change: five run-state bits and the device byte
  localparam logic [STAT_W-1:0] SW_OWN = {{5{1'b1}}, {(DEV_W-5){1'b0}}, {DEV_W{1'b1}}};

  logic [STAT_W-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (sw_we)
      stat_d = (stat_d & ~(sw_mask & SW_OWN)) | (sw_val & sw_mask & SW_OWN);
    // hardware applied last so it wins on shared device bits
    if (hw_we)
      stat_d[DEV_W-1:0] = (stat_d[DEV_W-1:0] & ~hw_mask) | (hw_val & hw_mask);
    if (br_upd)
      stat_d[BR_BIT] = br_take;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end

  always_comb begin
    stat_word          = stat_q;
    stat_word[ACT_BIT] = stat_q[RUN_BIT] & ~stat_q[DEAD_BIT];
  end

  assign dev_stat = stat_q[DEV_W-1:0];

  AST_SW_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
    (sw_we && !hw_we && !br_upd) |=>
      ((stat_q & ~$past(sw_mask) & SW_OWN) == ($past(stat_q) & ~$past(sw_mask) & SW_OWN))); // R2

  AST_HW_MASK_WINS: assert property (@(posedge clk) disable iff (rst)
    hw_we |=> ((stat_q[DEV_W-1:0] & $past(hw_mask)) == ($past(hw_val) & $past(hw_mask)))); // R4

  AST_BRANCH_TRACK: assert property (@(posedge clk) disable iff (rst)
    br_upd |=> (stat_q[BR_BIT] == $past(br_take))); // R8

  AST_BRANCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !br_upd |=> $stable(stat_q[BR_BIT])); // R8

endmodule

// File: rtl/chan_selector.sv
module chan_selector #(
  parameter int DEV_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [2*DEV_W-1:0] wdata,
  output logic [DEV_W-1:0]   sel_mask,
  output logic [DEV_W-1:0]   sel_val
);

  logic [2*DEV_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst)     sel_q <= '0;
    else if (we) sel_q <= wdata;
  end

  assign sel_mask = sel_q[2*DEV_W-1:DEV_W];
  assign sel_val  = sel_q[DEV_W-1:0];

endmodule

// File: rtl/chan_cond_eval.sv
module chan_cond_eval
  import chan_status_pkg::*;
#(
  parameter int DEV_W = 8
) (
  input  logic [DEV_W-1:0] dev,
  input  logic [DEV_W-1:0] mask,
  input  logic [DEV_W-1:0] val,
  input  logic [1:0]       code,
  output logic             fire
);

  logic hit;
  assign hit  = ((dev & mask) == val);
  assign fire = apply_gate(code, hit);

endmodule

// File: rtl/chan_status_unit.sv
module chan_status_unit
  import chan_status_pkg::*;
#(
  parameter int DEV_W  = 8,
  parameter int STAT_W = 2 * DEV_W,
  parameter int WORD_W = 2 * STAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [STAT_W-1:0] rd_data,
  input  logic              hw_dev_we,
  input  logic [DEV_W-1:0]  hw_dev_mask,
  input  logic [DEV_W-1:0]  hw_dev_val,
  input  logic              cmd_eval,
  input  logic [1:0]        int_code,
  input  logic [1:0]        br_code,
  input  logic [1:0]        wait_code,
  output logic              irq,
  output logic              branch_taken,
  output logic              wait_hold
);

  localparam int RUN_BIT  = STAT_W - 1;
  localparam int DEAD_BIT = STAT_W - 5;
  localparam int ACT_BIT  = STAT_W - 6;

  logic [STAT_W-1:0] stat_word;
  logic [DEV_W-1:0]  dev_stat;
  logic [DEV_W-1:0]  sel_mask [NUM_SEL];
  logic [DEV_W-1:0]  sel_val  [NUM_SEL];
  logic [1:0]        code_arr [NUM_SEL];
  logic [NUM_SEL-1:0] fire;
  logic              sw_we;

  assign sw_we       = wr_en && (wr_addr == ADR_STATUS);
  assign code_arr[0] = int_code;
  assign code_arr[1] = br_code;
  assign code_arr[2] = wait_code;

  chan_status_reg #(.DEV_W(DEV_W), .STAT_W(STAT_W)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .sw_we     (sw_we),
    .sw_mask   (wr_data[WORD_W-1:STAT_W]),
    .sw_val    (wr_data[STAT_W-1:0]),
    .hw_we     (hw_dev_we),
    .hw_mask   (hw_dev_mask),
    .hw_val    (hw_dev_val),
    .br_upd    (cmd_eval),
    .br_take   (fire[1]),
    .stat_word (stat_word),
    .dev_stat  (dev_stat)
  );

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    chan_selector #(.DEV_W(DEV_W)) u_sel (
      .clk      (clk),
      .rst      (rst),
      .we       (wr_en && (wr_addr == 2'(i + 1))),
      .wdata    (wr_data[STAT_W-1:0]),
      .sel_mask (sel_mask[i]),
      .sel_val  (sel_val[i])
    );

    chan_cond_eval #(.DEV_W(DEV_W)) u_eval (
      .dev  (dev_stat),
      .mask (sel_mask[i]),
      .val  (sel_val[i]),
      .code (code_arr[i]),
      .fire (fire[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data      <= '0;
      irq          <= 1'b0;
      branch_taken <= 1'b0;
      wait_hold    <= 1'b0;
    end else begin
      unique case (reg_addr_e'(rd_addr))
        ADR_STATUS:  rd_data <= stat_word;
        ADR_IRQ_SEL: rd_data <= {sel_mask[0], sel_val[0]};
        ADR_BR_SEL:  rd_data <= {sel_mask[1], sel_val[1]};
        default:     rd_data <= {sel_mask[2], sel_val[2]};
      endcase
      irq          <= cmd_eval & fire[0];
      branch_taken <= cmd_eval & fire[1];
      wait_hold    <= cmd_eval & fire[2];
    end
  end

  AST_ACTIVE_RULE: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADR_STATUS) |=>
      (rd_data[ACT_BIT] == (rd_data[RUN_BIT] && !rd_data[DEAD_BIT]))); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cmd_eval |=> (!irq && !branch_taken && !wait_hold)); // R7

  AST_NEVER_SILENT: assert property (@(posedge clk) disable iff (rst)
    (cmd_eval && int_code == GATE_NEVER) |=> !irq); // R7

  AST_ALWAYS_FIRES: assert property (@(posedge clk) disable iff (rst)
    (cmd_eval && wait_code == GATE_ALWAYS) |=> wait_hold); // R7

endmodule

// File: tb/tb_chan_status_unit.sv
module tb_chan_status_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        hw_dev_we = 1'b0;
  logic [7:0]  hw_dev_mask = '0;
  logic [7:0]  hw_dev_val = '0;
  logic        cmd_eval = 1'b0;
  logic [1:0]  int_code = '0;
  logic [1:0]  br_code = '0;
  logic [1:0]  wait_code = '0;
  logic        irq, branch_taken, wait_hold;

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  chan_status_unit dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hw_dev_we(hw_dev_we),
    .hw_dev_mask(hw_dev_mask), .hw_dev_val(hw_dev_val), .cmd_eval(cmd_eval),
    .int_code(int_code), .br_code(br_code), .wait_code(wait_code),
    .irq(irq), .branch_taken(branch_taken), .wait_hold(wait_hold)
  );

  // reference model
  logic [15:0] m_stat;
  logic [15:0] m_sel [3];
  logic [15:0] m_rd;
  logic        m_irq, m_br, m_wait;

  function automatic bit m_hit(int idx);
    return ((m_stat[7:0] & m_sel[idx][15:8]) == m_sel[idx][7:0]);
  endfunction

  function automatic bit m_gate(logic [1:0] c, bit h);
    if (c == 2'd0) return 1'b0;
    if (c == 2'd1) return h;
    if (c == 2'd2) return !h;
    return 1'b1;
  endfunction

  function automatic logic [15:0] m_view();
    logic [15:0] v = m_stat;
    v[10] = m_stat[15] && !m_stat[11];
    v[9]  = 1'b0;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_stat = '0;
      for (int k = 0; k < 3; k++) m_sel[k] = '0;
      m_rd = '0; m_irq = 0; m_br = 0; m_wait = 0;
    end else begin
      bit b_now;
      m_rd   = (rd_addr == 0) ? m_view() : m_sel[rd_addr - 1];
      b_now  = m_gate(br_code, m_hit(1));
      m_irq  = cmd_eval && m_gate(int_code, m_hit(0));
      m_br   = cmd_eval && b_now;
      m_wait = cmd_eval && m_gate(wait_code, m_hit(2));
      if (wr_en) begin
        if (wr_addr == 0) begin
          for (int b = 0; b < 16; b++)
            if ((b >= 11 || b <= 7) && wr_data[16 + b]) m_stat[b] = wr_data[b];
        end else begin
          m_sel[wr_addr - 1] = wr_data[15:0];
        end
      end
      if (hw_dev_we)
        for (int b = 0; b < 8; b++) if (hw_dev_mask[b]) m_stat[b] = hw_dev_val[b];
      if (cmd_eval) m_stat[8] = b_now;
    end
  end

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // wait for the next negedge, compare with the model, drop one-cycle strobes
  task automatic step();
    @(negedge clk);
    check(tag, "rd_data", rd_data, m_rd);
    check(tag, "irq", {15'b0, irq}, {15'b0, m_irq});
    check(tag, "branch_taken", {15'b0, branch_taken}, {15'b0, m_br});
    check(tag, "wait_hold", {15'b0, wait_hold}, {15'b0, m_wait});
    wr_en = 0; hw_dev_we = 0; cmd_eval = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; step();
  endtask

  task automatic rd_expect(logic [1:0] a, logic [15:0] exp, string req);
    rd_addr = a; step();
    check(req, "read", rd_data, exp);
  endtask

  task automatic eval_expect(logic [1:0] c, bit ei, bit eb, bit ew, string req);
    cmd_eval = 1; int_code = c; br_code = c; wait_code = c; step();
    check(req, "irq gate", {15'b0, irq}, {15'b0, ei});
    check(req, "branch gate", {15'b0, branch_taken}, {15'b0, eb});
    check(req, "wait gate", {15'b0, wait_hold}, {15'b0, ew});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    tag = "R1";
    step();
    for (int a = 0; a < 4; a++) rd_expect(2'(a), 16'h0000, "R1");

    tag = "R2";
    wr(0, {16'h00FF, 16'h00FF});
    wr(0, {16'h0003, 16'h0000});
    rd_expect(0, 16'h00FC, "R2");

    tag = "R3";
    wr(0, {16'h8000, 16'h8000});
    rd_expect(0, 16'h84FC, "R3");
    wr(0, {16'h0800, 16'h0800});
    rd_expect(0, 16'h88FC, "R3");
    wr(0, {16'h0700, 16'h0700});
    rd_expect(0, 16'h88FC, "R2");
    wr(0, {16'h0800, 16'h0000});
    rd_expect(0, 16'h84FC, "R3");

    tag = "R5";
    wr(1, {16'hDEAD, 16'h0F05});
    wr(2, {16'hBEEF, 16'hF0A0});
    wr(3, {16'h1234, 16'h0101});
    rd_expect(1, 16'h0F05, "R5");
    rd_expect(2, 16'hF0A0, "R5");
    rd_expect(3, 16'h0101, "R5");

    // device byte 0xFC: all three conditions false (R6)
    tag = "R7";
    eval_expect(0, 0, 0, 0, "R7");
    eval_expect(1, 0, 0, 0, "R6");
    eval_expect(2, 1, 1, 1, "R7");
    eval_expect(3, 1, 1, 1, "R7");
    // device byte 0x05: interrupt and wait true, branch false
    hw_dev_we = 1; hw_dev_mask = 8'hFF; hw_dev_val = 8'h05; step();
    eval_expect(1, 1, 0, 1, "R6");
    eval_expect(2, 0, 1, 0, "R7");

    tag = "R8";
    eval_expect(3, 1, 1, 1, "R8");
    rd_expect(0, 16'h8505, "R8");
    step();
    rd_expect(0, 16'h8505, "R8");
    eval_expect(0, 0, 0, 0, "R8");
    rd_expect(0, 16'h8405, "R8");

    tag = "R4";
    wr_en = 1; wr_addr = 0; wr_data = {16'h00FF, 16'h0000};
    hw_dev_we = 1; hw_dev_mask = 8'h0F; hw_dev_val = 8'h0A; step();
    rd_expect(0, 16'h840A, "R4");

    tag = "R9";
    wr_en = 1; wr_addr = 1; wr_data = {16'h0, 16'h0000};
    cmd_eval = 1; int_code = 1; br_code = 0; wait_code = 0; step();
    check("R9", "irq same cycle", {15'b0, irq}, 16'h0000);
    cmd_eval = 1; int_code = 1; step();
    check("R9", "irq next cycle", {15'b0, irq}, 16'h0001);

    tag = "R10 R6 R7 random";
    for (int n = 0; n < 4000; n++) begin
      wr_en = ($urandom % 3) == 0;
      wr_addr = 2'($urandom);
      wr_data = $urandom;
      rd_addr = 2'($urandom);
      hw_dev_we = ($urandom % 3) == 0;
      hw_dev_mask = 8'($urandom);
      hw_dev_val = 8'($urandom);
      cmd_eval = ($urandom % 2) == 0;
      int_code = 2'($urandom);
      br_code = 2'($urandom);
      wait_code = 2'($urandom);
      step();
    end

    tag = "R1";
    rst = 1; step(); rst = 0;
    for (int a = 0; a < 4; a++) rd_expect(2'(a), 16'h0000, "R1");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule